// File: doc/BRIEF.md
# Frame-Synchronous ADC Sample Collector

This block is the host-side master of a frame-synchronous serial link to one or two delta-sigma converters. It divides the system clock into a bit clock and marks each frame with a strobe that lasts one bit period. Each frame holds a fixed, exact number of bit periods. The strobe edge makes every converter present the most significant bit of its new result. The collector samples its data input(s) at each bit-clock rising edge. It assembles whole sample words and hands them out as single-cycle valid pulses, each tagged with a channel number.

Two wiring schemes are supported. In the chained scheme, one data line carries the slots of both converters back to back, nearest converter first. A slot is 24 bits wide, or 32 bits when each converter appends an 8-bit status word. Any bit periods left over at the end of a frame are idle. In the parallel scheme, both converters share strobe and bit clock and each drives its own data line. Only the first 24 bits of each result are captured, so a frame can be as short as 24 bit periods.

An enable input starts framing from idle. Dropping it ends framing only once the frame in progress is complete.

Top module: `adc_fs_capture`

## Requirements
- R1: The bit clock period is exactly 2*HALF_DIV system clocks: low for the first HALF_DIV, high for the second. The bit clock rests low whenever no frame is running.
- R2: Every frame lasts exactly FRAME_BITS bit-clock periods and frames follow each other with no gap. The strobe is high during the first bit period of each frame and low during all others.
- R3: Serial data is sampled at the system clock edge where the bit clock rises. The first bit sampled after the strobe rises is the most significant bit of the slot.
- R4: In the chained scheme, slot k occupies bit periods k*SLOT_BITS up to (k+1)*SLOT_BITS-1 of the frame, and its sample is tagged channel k. The first slot, from the nearest converter, is channel 0.
- R5: With 32-bit slots in the chained scheme, the sample is the upper 24 bits of the slot, the status is the lower 8 bits, and status_valid is 1. With 24-bit slots or in the parallel scheme, status is 0 and status_valid is 0.
- R6: Data on bit periods beyond the last slot of a frame produces no output.
- R7: In the parallel scheme, line 0 (sdata_i[0]) gives channel 0 and line 1 gives channel 1, each from the first 24 bits of the frame. Channel 0 is presented first, and channel 1 in the following system clock cycle.
- R8: Each sample is a single-cycle valid pulse. It appears in the second system clock cycle after the edge that captures the slot's last bit.
- R9: From idle, a high enable raises the strobe at the next clock edge. A low enable takes effect only at a frame end, so the last frame is always complete.
- R10: While reset is high, the bit clock, strobe and all sample outputs are 0.

Top module parameters: HALF_DIV, FRAME_BITS, SLOT_BITS (24 or 32), NUM_DEV (1 or 2), PARALLEL (0 chained, 1 parallel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start/stop framing, honoured at frame boundaries |
| sclk_o | output | 1 | Bit clock to the converters |
| fsync_o | output | 1 | Frame strobe, high for the first bit period |
| sdata_i | input | 2 | Serial data lines; only bit 0 used when chained |
| smp_valid_o | output | 1 | One-cycle sample strobe |
| smp_chan_o | output | 1 | Channel index of the sample |
| smp_data_o | output | 24 | Sample word, MSB first on the line |
| smp_status_o | output | 8 | Status byte when carried, else 0 |
| smp_status_valid_o | output | 1 | Status field carries data |

## Verification
Behavioural converter models load fresh words at each strobe rise and shift on each bit-clock fall. They are tried in three setups: chained 32-bit slots with two idle bit periods, chained 24-bit slots filling the frame under an odd divider, and parallel lines with 24-bit frames at the fastest divider. The first frame's words are 0x800001 and 0x7FFFFE, so a bit-order or off-by-one error shows at once. Later words vary per frame and per channel, which separates channel swaps and slot-offset faults. Idle periods are fed random data to show that they produce nothing. Enable is dropped at an arbitrary point mid-frame, which tests whether the frame in progress is cut short.

// File: rtl/adc_fs_pkg.sv
package adc_fs_pkg;
  localparam int SAMPLE_W = 24;
  localparam int STATUS_W = 8;

  typedef struct packed {
    logic [SAMPLE_W-1:0] sample;
    logic [STATUS_W-1:0] status;
    logic                status_ok;
    logic                chan;
  } fs_word_t;
endpackage

// File: rtl/adc_fs_timing.sv
// Bit clock divider and frame sequencer.
module adc_fs_timing #(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_BITS = 66,
  localparam int PH_W = (2*HALF_DIV > 2) ? $clog2(2*HALF_DIV) : 1,
  localparam int BC_W = $clog2(FRAME_BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  output logic            sclk_o,
  output logic            fsync_o,
  output logic            cap_stb_o,
  output logic [BC_W-1:0] cap_bit_o
);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF_DIV - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2*HALF_DIV - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_BITS - 1);

  logic            running;
  logic [PH_W-1:0] ph;
  logic [BC_W-1:0] bcnt;
  logic            rise_now, bit_end;

  assign rise_now  = running && (ph == PH_RISE);
  assign bit_end   = running && (ph == PH_LAST);
  assign cap_stb_o = rise_now;
  assign cap_bit_o = bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      ph      <= '0;
      bcnt    <= '0;
      sclk_o  <= 1'b0;
      fsync_o <= 1'b0;
    end else if (!running) begin
      ph     <= '0;
      bcnt   <= '0;
      sclk_o <= 1'b0;
      if (enable) begin
        running <= 1'b1;
        fsync_o <= 1'b1;
      end
    end else begin
      if (rise_now) sclk_o <= 1'b1;
      if (bit_end) begin
        ph      <= '0;
        sclk_o  <= 1'b0;
        fsync_o <= 1'b0;
        if (bcnt == BC_LAST) begin
          bcnt <= '0;
          if (enable) fsync_o <= 1'b1;
          else        running <= 1'b0;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assert_strobe_first_bit_R2: assert property (@(posedge clk) disable iff (rst)
    fsync_o |-> (running && bcnt == '0));
  assert_sclk_rest_low_R1: assert property (@(posedge clk) disable iff (rst)
    !running |-> !sclk_o);
  assert_stop_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> ($past(bcnt) == BC_LAST));
endmodule

// File: rtl/adc_fs_deser.sv
// Shifts one serial line into slot words, MSB first.
module adc_fs_deser #(
  parameter int SLOT_W = 32,
  parameter int NSLOTS = 2,
  parameter int BC_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_stb,
  input  logic [BC_W-1:0]   cap_bit,
  input  logic              din,
  output logic              word_valid_o,
  output logic [SLOT_W-1:0] word_o,
  output logic              slot_o
);
  localparam int SPAN = SLOT_W * NSLOTS;

  logic [SLOT_W-1:0] sreg, sreg_n;
  logic              at_end, slot_hi;
  int                idx;

  always_comb begin
    idx     = int'(cap_bit);
    sreg_n  = {sreg[SLOT_W-2:0], din};
    at_end  = cap_stb && (idx < SPAN) && ((idx % SLOT_W) == SLOT_W - 1);
    slot_hi = (idx >= SLOT_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg         <= '0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
      slot_o       <= 1'b0;
    end else begin
      if (cap_stb) sreg <= sreg_n;
      word_valid_o <= at_end;
      if (at_end) begin
        word_o <= sreg_n;
        slot_o <= slot_hi;
      end
    end
  end

  assert_word_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);
endmodule

// File: rtl/adc_fs_out.sv
// Splits slot words into sample/status and serialises the two parallel lanes.
module adc_fs_out
  import adc_fs_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter bit HAS_STATUS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_valid,
  input  logic [WORD_W-1:0] a_word,
  input  logic              a_slot,
  input  logic              b_valid,
  input  logic [WORD_W-1:0] b_word,
  output logic              out_valid_o,
  output fs_word_t          out_o
);
  logic              pend_q;
  logic [WORD_W-1:0] pend_word;

  function automatic fs_word_t split(input logic [WORD_W-1:0] w, input logic ch);
    fs_word_t r;
    r.sample    = w[WORD_W-1 -: SAMPLE_W];
    r.status    = HAS_STATUS ? w[STATUS_W-1:0] : '0;
    r.status_ok = HAS_STATUS;
    r.chan      = ch;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_o       <= '0;
      pend_q      <= 1'b0;
      pend_word   <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (a_valid) begin
        out_o       <= split(a_word, a_slot);
        out_valid_o <= 1'b1;
        if (b_valid) begin
          pend_q    <= 1'b1;
          pend_word <= b_word;
        end
      end else if (pend_q) begin
        out_o       <= split(pend_word, 1'b1);
        out_valid_o <= 1'b1;
        pend_q      <= 1'b0;
      end
    end
  end

  assert_pending_drains_R7: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> (out_valid_o && out_o.chan));
  assert_status_flag_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (out_o.status_ok == HAS_STATUS));
endmodule

// File: rtl/adc_fs_capture.sv
module adc_fs_capture
  import adc_fs_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_BITS = 66,
  parameter int SLOT_BITS  = 32,
  parameter int NUM_DEV    = 2,
  parameter bit PARALLEL   = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  output logic                sclk_o,
  output logic                fsync_o,
  input  logic [1:0]          sdata_i,
  output logic                smp_valid_o,
  output logic                smp_chan_o,
  output logic [SAMPLE_W-1:0] smp_data_o,
  output logic [STATUS_W-1:0] smp_status_o,
  output logic                smp_status_valid_o
);
  localparam int WORD_W     = PARALLEL ? SAMPLE_W : SLOT_BITS;
  localparam bit HAS_STATUS = !PARALLEL && (SLOT_BITS == 32);
  localparam int BC_W       = $clog2(FRAME_BITS);

  logic              cap_stb;
  logic [BC_W-1:0]   cap_bit;
  logic [1:0]        lane_v;
  logic [1:0]        lane_s;
  logic [WORD_W-1:0] lane_w [2];
  fs_word_t          out_w;
  logic              unused_slot;

  adc_fs_timing #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_timing (
    .clk(clk), .rst(rst), .enable(enable), .sclk_o(sclk_o), .fsync_o(fsync_o),
    .cap_stb_o(cap_stb), .cap_bit_o(cap_bit)
  );

  if (PARALLEL) begin : g_par
    for (genvar g = 0; g < 2; g++) begin : g_lane
      if (g < NUM_DEV) begin : g_on
        adc_fs_deser #(.SLOT_W(SAMPLE_W), .NSLOTS(1), .BC_W(BC_W)) u_deser (
          .clk(clk), .rst(rst), .cap_stb(cap_stb), .cap_bit(cap_bit), .din(sdata_i[g]),
          .word_valid_o(lane_v[g]), .word_o(lane_w[g]), .slot_o(lane_s[g])
        );
      end else begin : g_off
        logic unused_din;
        assign unused_din = sdata_i[g];
        assign lane_v[g]  = 1'b0;
        assign lane_w[g]  = '0;
        assign lane_s[g]  = 1'b0;
      end
    end
  end else begin : g_chain
    logic unused_din;
    adc_fs_deser #(.SLOT_W(SLOT_BITS), .NSLOTS(NUM_DEV), .BC_W(BC_W)) u_deser (
      .clk(clk), .rst(rst), .cap_stb(cap_stb), .cap_bit(cap_bit), .din(sdata_i[0]),
      .word_valid_o(lane_v[0]), .word_o(lane_w[0]), .slot_o(lane_s[0])
    );
    assign unused_din = sdata_i[1];
    assign lane_v[1]  = 1'b0;
    assign lane_w[1]  = '0;
    assign lane_s[1]  = 1'b0;
  end

  assign unused_slot = lane_s[1];

  adc_fs_out #(.WORD_W(WORD_W), .HAS_STATUS(HAS_STATUS)) u_out (
    .clk(clk), .rst(rst),
    .a_valid(lane_v[0]), .a_word(lane_w[0]), .a_slot(lane_s[0]),
    .b_valid(lane_v[1]), .b_word(lane_w[1]),
    .out_valid_o(smp_valid_o), .out_o(out_w)
  );

  assign smp_chan_o         = out_w.chan;
  assign smp_data_o         = out_w.sample;
  assign smp_status_o       = out_w.status;
  assign smp_status_valid_o = out_w.status_ok;
endmodule

// File: tb/adc_fs_capture_tb_top.sv
`timescale 1ns/1ps

// One configuration: converter models, reference predictor and comparator.
module adc_fs_env #(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_BITS = 66,
  parameter int SLOT_BITS  = 32,
  parameter int NUM_DEV    = 2,
  parameter bit PARALLEL   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic chk_idle,
  output int   n_chk,
  output int   n_fail
);
  logic        sclk, fsync, v, ch, sv;
  logic [23:0] dat;
  logic [7:0]  st;
  logic [1:0]  sdata;

  adc_fs_capture #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS), .SLOT_BITS(SLOT_BITS),
                   .NUM_DEV(NUM_DEV), .PARALLEL(PARALLEL)) dut_i (
    .clk(clk), .rst(rst), .enable(en), .sclk_o(sclk), .fsync_o(fsync), .sdata_i(sdata),
    .smp_valid_o(v), .smp_chan_o(ch), .smp_data_o(dat), .smp_status_o(st),
    .smp_status_valid_o(sv)
  );

  function automatic logic [23:0] smp(input int f, input int d);
    if (f == 0) return (d != 0) ? 24'h7FFFFE : 24'h800001;
    return 24'((f * 40503 + d * 11141) ^ (f << 13) ^ ((d != 0) ? 24'hC3A50F : 24'h1E2D3C));
  endfunction

  function automatic logic [7:0] sts(input int f, input int d);
    return 8'((f * 7) ^ ((d != 0) ? 8'hA0 : 8'h50));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (cfg par=%0d slot=%0d) actual=%0h expected=%0h",
               req, PARALLEL, SLOT_BITS, act, exp);
    end
  endtask

  // sched slot [1] = next negedge, [2] = the one after
  bit          e_v [3];
  bit          e_c [3];
  logic [23:0] e_d [3];
  logic [7:0]  e_s [3];
  bit          e_sv[3];

  int fr = -1, idx = 0, rc = 0, cyc = 0, last_rise = 0;
  bit fs_p = 0, sc_p = 0, en_p = 0, started = 0, start_chk = 0;

  initial begin
    n_chk = 0; n_fail = 0; sdata = '0;
    for (int i = 0; i < 3; i++) begin e_v[i] = 0; e_c[i] = 0; e_d[i] = '0; e_s[i] = '0; e_sv[i] = 0; end
  end

  always @(negedge clk) begin
    bit fs_r, sc_r, sc_f, cv, cc, csv;
    logic [23:0] cd;
    logic [7:0]  cs;
    if (rst) begin
      chk(!sclk && !fsync && !v && !ch && dat == '0 && st == '0 && !sv, "R10 reset state",
          {sclk, fsync, v, sv}, 32'h0);
      fs_p = 0; sc_p = 0; en_p = 0;
    end else begin
      cyc++;
      fs_r = fsync && !fs_p;
      sc_r = sclk && !sc_p;
      sc_f = !sclk && sc_p;
      cv = e_v[1]; cc = e_c[1]; cd = e_d[1]; cs = e_s[1]; csv = e_sv[1];
      e_v[1] = e_v[2]; e_c[1] = e_c[2]; e_d[1] = e_d[2]; e_s[1] = e_s[2]; e_sv[1] = e_sv[2];
      e_v[2] = 0;
      chk(v == cv, "R6/R8 valid pulse timing", 32'(v), 32'(cv));
      if (cv && v) begin
        chk(ch == cc, PARALLEL ? "R7 channel order" : "R4 channel tag", 32'(ch), 32'(cc));
        chk(dat == cd, "R3 sample bits MSB first", 32'(dat), 32'(cd));
        chk(st == cs && sv == csv, "R5 status field", {23'd0, sv, st}, {23'd0, csv, cs});
      end
      if (start_chk) begin
        chk(fsync, "R9 strobe follows enable", 32'(fsync), 32'd1);
        start_chk = 0;
      end
      if (en && !en_p) start_chk = 1;
      if (chk_idle) begin
        chk(!sclk && !fsync, "R1 idle bit clock low", {30'd0, sclk, fsync}, 32'd0);
        chk(rc == FRAME_BITS, "R9 last frame completed", 32'(rc), 32'(FRAME_BITS));
      end
      if (fs_r) begin
        if (started) chk(rc == FRAME_BITS, "R2 bit clocks per frame", 32'(rc), 32'(FRAME_BITS));
        started = 1; rc = 0; fr++; idx = 0;
      end else if (sc_f) begin
        idx++;
      end
      if (sc_r) begin
        int b;
        b = rc;
        if (rc > 0) chk(cyc - last_rise == 2*HALF_DIV, "R1 bit clock period",
                        32'(cyc - last_rise), 32'(2*HALF_DIV));
        last_rise = cyc;
        rc++;
        chk(fsync == (b == 0), "R2 strobe only on first bit", 32'(fsync), 32'(b == 0));
        if (!PARALLEL) begin
          if (b < NUM_DEV*SLOT_BITS && (b % SLOT_BITS) == SLOT_BITS - 1) begin
            int d;
            d = b / SLOT_BITS;
            e_v[1] = 1; e_c[1] = (d != 0); e_d[1] = smp(fr, d);
            e_s[1] = (SLOT_BITS == 32) ? sts(fr, d) : 8'h00; e_sv[1] = (SLOT_BITS == 32);
          end
        end else if (b == 23) begin
          e_v[1] = 1; e_c[1] = 0; e_d[1] = smp(fr, 0); e_s[1] = 8'h00; e_sv[1] = 0;
          if (NUM_DEV == 2) begin
            e_v[2] = 1; e_c[2] = 1; e_d[2] = smp(fr, 1); e_s[2] = 8'h00; e_sv[2] = 0;
          end
        end
      end
      // converter models drive the lines (changes follow bit clock falls)
      for (int ln = 0; ln < 2; ln++) begin
        logic bitv;
        bitv = 1'($urandom);
        if (fr >= 0) begin
          if (!PARALLEL) begin
            if (ln == 0 && idx < NUM_DEV*SLOT_BITS) begin
              logic [31:0] w;
              int k;
              k = idx / SLOT_BITS;
              w = (SLOT_BITS == 32) ? {smp(fr, k), sts(fr, k)} : {8'h00, smp(fr, k)};
              bitv = w[SLOT_BITS - 1 - (idx % SLOT_BITS)];
            end
          end else if (ln < NUM_DEV && idx < 32) begin
            logic [31:0] w;
            w = {smp(fr, ln), sts(fr, ln)};
            bitv = w[31 - idx];
          end
        end
        sdata[ln] = bitv;
      end
      fs_p = fsync; sc_p = sclk; en_p = en;
    end
  end
endmodule

module adc_fs_capture_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic chk_idle = 1'b0;
  int   c0, f0, c1, f1, c2, f2;
  int   wd_chk = 0, wd_fail = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  adc_fs_env #(.HALF_DIV(2), .FRAME_BITS(66), .SLOT_BITS(32), .NUM_DEV(2), .PARALLEL(1'b0)) env_c32 (
    .clk(clk), .rst(rst), .en(en), .chk_idle(chk_idle), .n_chk(c0), .n_fail(f0));
  adc_fs_env #(.HALF_DIV(3), .FRAME_BITS(48), .SLOT_BITS(24), .NUM_DEV(2), .PARALLEL(1'b0)) env_c24 (
    .clk(clk), .rst(rst), .en(en), .chk_idle(chk_idle), .n_chk(c1), .n_fail(f1));
  adc_fs_env #(.HALF_DIV(1), .FRAME_BITS(24), .SLOT_BITS(32), .NUM_DEV(2), .PARALLEL(1'b1)) env_par (
    .clk(clk), .rst(rst), .en(en), .chk_idle(chk_idle), .n_chk(c2), .n_fail(f2));

  task automatic report();
    int tot, bad;
    tot = c0 + c1 + c2 + wd_chk;
    bad = f0 + f1 + f2 + wd_fail;
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle_probe();
    step(1); chk_idle = 1'b1;
    step(1); chk_idle = 1'b0;
  endtask

  initial begin
    step(6);
    rst = 1'b0;
    step(3);
    en = 1'b1;
    step(4001);
    en = 1'b0;                // arbitrary point inside a frame
    step(800);
    idle_probe();
    en = 1'b1;
    step(3117);
    en = 1'b0;
    step(800);
    idle_probe();
    step(10);
    done = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      wd_chk++; wd_fail++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      report();
    end
  end
endmodule